// File: doc/BRIEF.md
# Seconds Counter with Alarm Match

This block is a memory-mapped real-time seconds counter for a simple 32-bit register bus. A 32-bit count advances by one each time a one-cycle tick enable pulses; the tick is produced elsewhere from a slow reference clock, once per second. Software reads the running count and sets it through a separate load register. It also programs a match value.

When a tick makes the count equal to the match value, a sticky raw alarm flag is raised. A mask bit gates the raw flag into a masked status, and the interrupt output is a level that follows the masked status. Software clears the raw flag by writing a 1 to a write-only clear register.

The bus is a single-cycle write strobe with a combinational read. The word index is taken from address bits [ADDR_W-1:2], and the two low address bits are ignored.

Top module: `sec_alarm_counter`

## Requirements
- R1: After reset the count, the match value, the mask bit, the raw flag and `irq` are all 0.
- R2: A cycle with `tick_en` high and no load write adds one to the count, and 0xFFFFFFFF goes to 0. With no tick and no load, the count holds.
- R3: Writing offset 0x08 (load) replaces the count with `wdata`, and this takes precedence over a tick in the same cycle. Reading offset 0x00 returns the running count.
- R4: Offset 0x04 is the match register, and it reads back the last value written to it.
- R5: The raw flag is set by a tick that makes the count equal to the match value. It stays set while the count moves on. A load that puts the count equal to the match value does not set it.
- R6: Writing 1 to bit 0 of offset 0x1C clears the raw flag. Writing 0 there has no effect. Offset 0x1C reads as 0.
- R7: When the alarm is set and cleared in the same cycle, the set wins and the raw flag ends up 1.
- R8: Bit 0 of offset 0x10 is the mask bit, and its upper bits read 0. Offset 0x14 bit 0 returns the raw flag whatever the mask. Offset 0x18 bit 0 returns the raw flag AND the mask bit.
- R9: `irq` is high exactly when the raw flag and the mask bit are both 1.
- R10: Offset 0x0C reads 1 in bit 0 (counter running), and writes to it have no effect. Offsets 0x20 and above read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse that advances the count |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data of the register at `addr`, combinational |
| irq | output | 1 | Alarm interrupt level |

## Verification
Two pairs of events can land in the same cycle. In the first, the tick that reaches the match value arrives together with a software write of 1 to the clear register. The bench drives both on one edge and then expects the raw status and `irq` to read 1. In the second, a load write coincides with a tick; the bench expects the count to equal the loaded value and no alarm to be raised.

// File: rtl/sec_alarm_counter.sv
module sec_alarm_counter #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] IDX_COUNT = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_MATCH = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_LOAD  = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_CTRL  = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX_MASK  = IDX_W'(4);
  localparam logic [IDX_W-1:0] IDX_RAW   = IDX_W'(5);
  localparam logic [IDX_W-1:0] IDX_MSKD  = IDX_W'(6);
  localparam logic [IDX_W-1:0] IDX_CLR   = IDX_W'(7);

  logic [DATA_W-1:0] count_q, match_q, count_inc;
  logic              mask_q, raw_q;
  logic [IDX_W-1:0]  idx;
  logic              wr_load, wr_match, wr_mask, clr_hit, set_hit;

  assign idx       = addr[ADDR_W-1:2];
  assign wr_load   = wr_en && (idx == IDX_LOAD);
  assign wr_match  = wr_en && (idx == IDX_MATCH);
  assign wr_mask   = wr_en && (idx == IDX_MASK);
  assign clr_hit   = wr_en && (idx == IDX_CLR) && wdata[0];
  assign count_inc = count_q + DATA_W'(1);
  assign set_hit   = tick_en && !wr_load && (count_inc == match_q);
  assign irq       = raw_q & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      match_q <= '0;
      mask_q  <= 1'b0;
      raw_q   <= 1'b0;
    end else begin
      if (wr_load)      count_q <= wdata;
      else if (tick_en) count_q <= count_inc;
      if (wr_match) match_q <= wdata;
      if (wr_mask)  mask_q  <= wdata[0];
      if (set_hit)      raw_q <= 1'b1;
      else if (clr_hit) raw_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr < ADDR_W'(32)) begin
      case (idx)
        IDX_COUNT: rdata = count_q;
        IDX_MATCH: rdata = match_q;
        IDX_CTRL:  rdata = DATA_W'(1);
        IDX_MASK:  rdata = DATA_W'(mask_q);
        IDX_RAW:   rdata = DATA_W'(raw_q);
        IDX_MSKD:  rdata = DATA_W'(raw_q & mask_q);
        default:   rdata = '0;
      endcase
    end
  end

  assert_tick_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && !wr_load |=> count_q == $past(count_q) + DATA_W'(1));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en && !wr_load |=> $stable(count_q));

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> count_q == $past(wdata));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    raw_q && !clr_hit |=> raw_q);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit && !tick_en |=> !raw_q);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit && tick_en && !wr_load && (count_q + DATA_W'(1) == match_q) |=> raw_q);
endmodule

// File: tb/tb_sec_alarm_counter.sv
module tb_sec_alarm_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sec_alarm_counter dut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
                         .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  // {wr, tick, waddr, wdata, raddr, expected, requirement number}
  localparam int NV = 17;
  localparam logic [81:0] VEC [NV] = '{
    {1'b1, 1'b0, 6'h08, 32'd5,          6'h00, 32'd5, 4'd3},  // R3 load
    {1'b0, 1'b1, 6'h00, 32'd0,          6'h00, 32'd6, 4'd2},  // R2 tick
    {1'b0, 1'b0, 6'h00, 32'd0,          6'h00, 32'd6, 4'd2},  // R2 hold
    {1'b1, 1'b0, 6'h04, 32'd8,          6'h04, 32'd8, 4'd4},  // R4 match
    {1'b0, 1'b1, 6'h00, 32'd0,          6'h14, 32'd0, 4'd5},  // R5 count 7
    {1'b0, 1'b1, 6'h00, 32'd0,          6'h14, 32'd1, 4'd5},  // R5 count 8 hits
    {1'b0, 1'b1, 6'h00, 32'd0,          6'h14, 32'd1, 4'd5},  // R5 sticky at 9
    {1'b0, 1'b0, 6'h00, 32'd0,          6'h18, 32'd0, 4'd8},  // R8 masked off
    {1'b1, 1'b0, 6'h10, 32'd1,          6'h18, 32'd1, 4'd8},  // R8 masked on
    {1'b1, 1'b0, 6'h1C, 32'd0,          6'h14, 32'd1, 4'd6},  // R6 write 0
    {1'b1, 1'b0, 6'h1C, 32'd1,          6'h14, 32'd0, 4'd6},  // R6 clear
    {1'b0, 1'b0, 6'h00, 32'd0,          6'h1C, 32'd0, 4'd6},  // R6 reads 0
    {1'b1, 1'b0, 6'h08, 32'd8,          6'h14, 32'd0, 4'd5},  // R5 load no set
    {1'b0, 1'b0, 6'h00, 32'd0,          6'h0C, 32'd1, 4'd10}, // R10 ctrl
    {1'b1, 1'b0, 6'h0C, 32'd0,          6'h0C, 32'd1, 4'd10}, // R10 ctrl write
    {1'b1, 1'b0, 6'h24, 32'hFFFF,       6'h00, 32'd8, 4'd10}, // R10 unmapped write
    {1'b1, 1'b0, 6'h10, 32'hFFFFFFFF,   6'h10, 32'd1, 4'd8}   // R8 mask width
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic t, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = w; tick_en = t; addr = a; wdata = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0; tick_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    addr = a;
    #0.5;
    v = rdata;
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    rd(6'h00, v); check(1, v, 32'd0);
    rd(6'h04, v); check(1, v, 32'd0);
    rd(6'h10, v); check(1, v, 32'd0);
    rd(6'h14, v); check(1, v, 32'd0);
    check(1, {31'd0, irq}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][81], VEC[i][80], VEC[i][79:74], VEC[i][73:42]);
      rd(VEC[i][41:36], v);
      check(int'(VEC[i][3:0]), v, VEC[i][35:4]);
    end

    // R10 unmapped read
    rd(6'h20, v); check(10, v, 32'd0);
    // R2 wrap
    step(1'b1, 1'b0, 6'h08, 32'hFFFFFFFF);
    step(1'b0, 1'b1, 6'h00, 32'd0);
    rd(6'h00, v); check(2, v, 32'd0);
    // R3 load beats tick
    step(1'b1, 1'b1, 6'h08, 32'd100);
    rd(6'h00, v); check(3, v, 32'd100);
    // R7 set and clear in one cycle, mask is 1
    step(1'b1, 1'b0, 6'h04, 32'd10);
    step(1'b1, 1'b0, 6'h08, 32'd9);
    step(1'b1, 1'b1, 6'h1C, 32'd1);
    rd(6'h14, v); check(7, v, 32'd1);
    check(9, {31'd0, irq}, 32'd1);   // R9 irq high
    // R8 raw visible while masked, R9 irq low
    step(1'b1, 1'b0, 6'h10, 32'd0);
    rd(6'h14, v); check(8, v, 32'd1);
    rd(6'h18, v); check(8, v, 32'd0);
    check(9, {31'd0, irq}, 32'd0);
    // R6 clear ends irq after unmasking
    step(1'b1, 1'b0, 6'h10, 32'd1);
    check(9, {31'd0, irq}, 32'd1);
    step(1'b1, 1'b0, 6'h1C, 32'd1);
    check(6, {31'd0, irq}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule